// File: doc/BRIEF.md
# Descriptor-Chained Memory-to-Stream DMA Engine

This block is the outbound half of one DMA channel. On a start strobe it reads a chain of four-word data descriptors from memory, streams the bytes of each buffer to a client one byte per beat, and writes each descriptor back once its buffer is used up. The client sees a valid/ready byte stream with an end-of-packet flag, and a separate valid/ready metadata channel that carries a 16-bit tag once per packet. A single memory request port carries descriptor fetches, descriptor writebacks, data word reads and the read-modify-write of the enclosing context descriptor at the end of the list.

The caller supplies the address of the first descriptor, the byte position to start from inside that descriptor's buffer, and the address of the context descriptor that owns the chain. Long buffers are sent in chunks of at most `CHUNK_MAX` bytes. The engine stops at a descriptor marked as the end of the list and sets a sticky flag that the next start clears.

Back-pressure: a byte beat or a metadata word transfers only on a clock edge where both valid and ready are high. Once raised, valid stays high and the payload stays unchanged until that edge. On the memory port a request holds its address, direction and write data until the grant. Read data is taken on the first `mem_rvalid` after a granted read, and only one read is outstanding at a time.

Top module: `desc_stream_dma`

## Requirements
- R1: After reset `running`, `eol_flag`, `irq_set`, `st_valid`, `md_valid` and `mem_req` are all low.
- R2: A descriptor is four words at byte offsets 0, 4, 8 and 12 from its pointer: next pointer, buffer start, flags, buffer limit (first byte past the data). Flags bit 0 is end of list, bit 3 is output end of packet, bit 4 is interrupt request, and bits 31:16 are metadata. The first descriptor starts at `buf_pos`. Every later one starts at its buffer-start word.
- R3: Bytes go out in ascending address order from the start position up to the limit minus one. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the memory word at a with its two low bits cleared.
- R4: `st_eop` is high only on the final byte of a buffer, and only when flags bit 3 is set. A buffer longer than `CHUNK_MAX` is sent in several chunks with no end of packet between them.
- R5: Metadata (flags bits 31:16) goes out once, before any byte of the first descriptor, and before any byte of each descriptor that follows one with flags bit 3 set. No other descriptor sends metadata.
- R6: When a buffer is used up and flags bit 4 is set, `irq_set` is high for exactly one cycle, after the buffer's last byte and before the writeback.
- R7: Each finished descriptor is written back to its four word addresses, in order and unchanged.
- R8: After writing back a descriptor with flags bit 0 set, the engine reads the word at `ctx_ptr`+4, writes it back with bit 15 set, then raises `eol_flag` and drops `running`.
- R9: Otherwise the engine fetches the descriptor named by the next pointer and continues. Descriptors are processed in chain order.
- R10: A start while `running` is high is ignored. A start while idle clears `eol_flag` and raises `running` on the following cycle.
- R11: A descriptor whose start position equals its limit sends no byte but still raises its interrupt, is written back, and advances or ends the chain.
- R12: `st_valid` with its data and end-of-packet, `md_valid` with its data, and `mem_req` with its address and direction hold steady until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, one cycle |
| desc_ptr | input | 32 | Address of the first descriptor |
| buf_pos | input | 32 | Byte position to start from in the first buffer |
| ctx_ptr | input | 32 | Address of the enclosing context descriptor |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| st_valid | output | 1 | Byte beat valid |
| st_ready | input | 1 | Client accepts the byte beat |
| st_data | output | 8 | Byte payload |
| st_eop | output | 1 | Beat is the last of a packet |
| md_valid | output | 1 | Metadata valid |
| md_ready | input | 1 | Client accepts the metadata |
| md_data | output | 16 | Metadata payload |
| irq_set | output | 1 | Pulse: data interrupt bit to be raised |
| eol_flag | output | 1 | Sticky end-of-list reached |
| running | output | 1 | Engine active |

## Verification
Every stream, metadata and memory result counts at the clock edge where its handshake completes. The bench makes all of its ready, grant and read-data choices half a cycle earlier, then checks each transfer against the front of its expected queue at that moment. Read data comes back exactly one cycle after a granted read. `irq_set` is due in the single cycle after a buffer's last byte is accepted, or after setup for an empty buffer, so the bench ties each pulse to the count of bytes seen so far. Likewise each metadata word must arrive while the byte count still equals the index where its descriptor begins. A start lowers `eol_flag` and raises `running` one cycle later, and the bench checks them at the next sample point.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  localparam int WORD_W    = 32;
  localparam int MD_W      = 16;
  localparam int FL_EOL    = 0;
  localparam int FL_OEOP   = 3;
  localparam int FL_INTR   = 4;
  localparam int FL_MD_LSB = 16;
  localparam int CTX_DIS   = 15;
  localparam int W_NEXT    = 0;
  localparam int W_START   = 1;
  localparam int W_FLAGS   = 2;
  localparam int W_LIMIT   = 3;
  localparam int DESC_WORDS = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_META, S_SETUP, S_STREAM,
    S_DONE, S_WBACK, S_CTX_RD, S_CTX_WR
  } dsd_state_e;
endpackage

// File: rtl/dsd_chunk_calc.sv
module dsd_chunk_calc import dsd_pkg::*; #(
  parameter int CHUNK_MAX = 2048,
  parameter int CL_W      = 12
) (
  input  logic [WORD_W-1:0] pos,
  input  logic [WORD_W-1:0] limit,
  output logic              zero,
  output logic [CL_W-1:0]   len
);
  localparam logic [WORD_W-1:0] CAP = WORD_W'(CHUNK_MAX);
  logic [WORD_W-1:0] remain;

  always_comb begin
    remain = limit - pos;
    zero   = (remain == '0);
    len    = (remain > CAP) ? CAP[CL_W-1:0] : remain[CL_W-1:0];
  end
endmodule

// File: rtl/dsd_byte_lane.sv
module dsd_byte_lane import dsd_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [WORD_W-1:0] data,
  input  logic [WORD_W-1:0] pos,
  output logic              hit,
  output logic [7:0]        byte_o
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-3:0] tag_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      tag_q   <= '0;
      valid_q <= 1'b0;
    end else if (clear) begin
      valid_q <= 1'b0;
    end else if (load) begin
      word_q  <= data;
      tag_q   <= pos[WORD_W-1:2];
      valid_q <= 1'b1;
    end
  end

  always_comb begin
    hit    = valid_q && (tag_q == pos[WORD_W-1:2]);
    byte_o = word_q[8*pos[1:0] +: 8];
  end

  // R3: a data word is only fetched when the held word misses
  a_r3_fill_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !hit);
endmodule

// File: rtl/desc_stream_dma.sv
module desc_stream_dma import dsd_pkg::*; #(
  parameter int CHUNK_MAX = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] desc_ptr,
  input  logic [WORD_W-1:0] buf_pos,
  input  logic [WORD_W-1:0] ctx_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [7:0]        st_data,
  output logic              st_eop,
  output logic              md_valid,
  input  logic              md_ready,
  output logic [MD_W-1:0]   md_data,
  output logic              irq_set,
  output logic              eol_flag,
  output logic              running
);
  localparam int CL_W = $clog2(CHUNK_MAX + 1);

  dsd_state_e        state_q;
  logic [1:0]        widx_q;
  logic              pend_q, send_md_q, take_start_q, eol_q;
  logic [WORD_W-1:0] ptr_q, pos_q, ctx_q, ctx_word_q;
  logic [WORD_W-1:0] desc_q [DESC_WORDS];
  logic [CL_W-1:0]   chunk_left_q, chunk_len;
  logic              zero_len, hit, lane_load, lane_clear;
  logic [7:0]        lane_byte;
  logic              accept, beat, last_byte;

  assign accept     = mem_req && mem_gnt;
  assign beat       = st_valid && st_ready;
  assign last_byte  = (pos_q + WORD_W'(1)) == desc_q[W_LIMIT];
  assign lane_load  = (state_q == S_STREAM) && pend_q && mem_rvalid;
  assign lane_clear = (state_q == S_IDLE) && start;

  dsd_chunk_calc #(.CHUNK_MAX(CHUNK_MAX), .CL_W(CL_W)) u_calc (
    .pos(pos_q), .limit(desc_q[W_LIMIT]), .zero(zero_len), .len(chunk_len));

  dsd_byte_lane u_lane (
    .clk(clk), .rst_n(rst_n), .clear(lane_clear), .load(lane_load),
    .data(mem_rdata), .pos(pos_q), .hit(hit), .byte_o(lane_byte));

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      S_FETCH: begin
        mem_req  = !pend_q;
        mem_addr = ptr_q + WORD_W'({widx_q, 2'b00});
      end
      S_STREAM: begin
        mem_req  = !hit && !pend_q;
        mem_addr = {pos_q[WORD_W-1:2], 2'b00};
      end
      S_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q + WORD_W'({widx_q, 2'b00});
        mem_wdata = desc_q[widx_q];
      end
      S_CTX_RD: begin
        mem_req  = !pend_q;
        mem_addr = ctx_q + WORD_W'(4);
      end
      S_CTX_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ctx_q + WORD_W'(4);
        mem_wdata = ctx_word_q | (WORD_W'(1) << CTX_DIS);
      end
      default: ;
    endcase
  end

  always_comb begin
    st_valid = (state_q == S_STREAM) && hit;
    st_data  = lane_byte;
    st_eop   = (state_q == S_STREAM) && last_byte && desc_q[W_FLAGS][FL_OEOP];
    md_valid = (state_q == S_META);
    md_data  = desc_q[W_FLAGS][FL_MD_LSB +: MD_W];
    irq_set  = (state_q == S_DONE) && desc_q[W_FLAGS][FL_INTR];
    eol_flag = eol_q;
    running  = (state_q != S_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      widx_q       <= '0;
      pend_q       <= 1'b0;
      send_md_q    <= 1'b0;
      take_start_q <= 1'b0;
      eol_q        <= 1'b0;
      ptr_q        <= '0;
      pos_q        <= '0;
      ctx_q        <= '0;
      ctx_word_q   <= '0;
      chunk_left_q <= '0;
      for (int i = 0; i < DESC_WORDS; i++) desc_q[i] <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          ptr_q        <= desc_ptr;
          pos_q        <= buf_pos;
          ctx_q        <= ctx_ptr;
          eol_q        <= 1'b0;
          send_md_q    <= 1'b1;
          take_start_q <= 1'b0;
          widx_q       <= '0;
          state_q      <= S_FETCH;
        end
        S_FETCH: begin
          if (accept) pend_q <= 1'b1;
          if (pend_q && mem_rvalid) begin
            desc_q[widx_q] <= mem_rdata;
            pend_q         <= 1'b0;
            widx_q         <= widx_q + 2'd1;
            if (widx_q == 2'd3) begin
              if (take_start_q) pos_q <= desc_q[W_START];
              state_q <= send_md_q ? S_META : S_SETUP;
            end
          end
        end
        S_META: if (md_ready) begin
          send_md_q <= 1'b0;
          state_q   <= S_SETUP;
        end
        S_SETUP: begin
          if (zero_len) state_q <= S_DONE;
          else begin
            chunk_left_q <= chunk_len;
            state_q      <= S_STREAM;
          end
        end
        S_STREAM: begin
          if (accept) pend_q <= 1'b1;
          if (lane_load) pend_q <= 1'b0;
          if (beat) begin
            pos_q        <= pos_q + WORD_W'(1);
            chunk_left_q <= chunk_left_q - CL_W'(1);
            if (last_byte) state_q <= S_DONE;
            else if (chunk_left_q == CL_W'(1)) state_q <= S_SETUP;
          end
        end
        S_DONE: begin
          widx_q  <= '0;
          state_q <= S_WBACK;
        end
        S_WBACK: if (mem_gnt) begin
          widx_q <= widx_q + 2'd1;
          if (widx_q == 2'd3) begin
            if (desc_q[W_FLAGS][FL_EOL]) state_q <= S_CTX_RD;
            else begin
              ptr_q        <= desc_q[W_NEXT];
              take_start_q <= 1'b1;
              send_md_q    <= desc_q[W_FLAGS][FL_OEOP];
              state_q      <= S_FETCH;
            end
          end
        end
        S_CTX_RD: begin
          if (accept) pend_q <= 1'b1;
          if (pend_q && mem_rvalid) begin
            pend_q     <= 1'b0;
            ctx_word_q <= mem_rdata;
            state_q    <= S_CTX_WR;
          end
        end
        S_CTX_WR: if (mem_gnt) begin
          eol_q   <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R12: back-pressure holds on every outgoing handshake
  a_r12_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_eop));
  a_r12_meta_hold: assert property (@(posedge clk) disable iff (!rst_n)
    md_valid && !md_ready |=> md_valid && $stable(md_data));
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R6: interrupt request is a single-cycle pulse
  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> !irq_set);
  // R8: the end-of-list flag only stands while stopped
  a_r8_eol_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    eol_flag |-> !running);
endmodule

// File: tb/test_desc_stream_dma.sv
module test_desc_stream_dma;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0;
  logic [31:0] desc_ptr = '0, buf_pos = '0, ctx_ptr = '0;
  logic        mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        st_valid, st_ready = 1'b0, st_eop;
  logic [7:0]  st_data;
  logic        md_valid, md_ready = 1'b0;
  logic [15:0] md_data;
  logic        irq_set, eol_flag, running;

  desc_stream_dma #(.CHUNK_MAX(6)) i_desc_stream_dma (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_ptr(desc_ptr),
    .buf_pos(buf_pos), .ctx_ptr(ctx_ptr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .st_valid(st_valid),
    .st_ready(st_ready), .st_data(st_data), .st_eop(st_eop),
    .md_valid(md_valid), .md_ready(md_ready), .md_data(md_data),
    .irq_set(irq_set), .eol_flag(eol_flag), .running(running));

  int tests = 0, fails = 0, cycles = 0, bytes_seen = 0;
  logic [31:0] mem [0:255];
  logic [8:0]  exp_b_q[$];
  logic [15:0] exp_md_q[$];
  int          exp_md_at[$], exp_irq_at[$];
  logic [31:0] exp_wa_q[$], exp_wd_q[$];
  logic        rd_next = 1'b0;
  logic [31:0] rd_addr = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic        prev_st_wait = 1'b0, prev_md_wait = 1'b0;
  logic [8:0]  prev_st = '0;
  logic [15:0] prev_md = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[9:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  // Behavioural walk of the chain: fills the expected event queues
  task automatic build(input logic [31:0] d0, input logic [31:0] p0, input logic [31:0] c);
    logic [31:0] d, p, nx, stt, fl, lim;
    bit smd;
    int idx;
    d = d0; p = p0; smd = 1'b1; idx = 0;
    for (int k = 0; k < 16; k++) begin
      nx = mem[d[9:2]]; stt = mem[d[9:2]+1]; fl = mem[d[9:2]+2]; lim = mem[d[9:2]+3];
      if (k != 0) p = stt;
      if (smd) begin exp_md_q.push_back(fl[31:16]); exp_md_at.push_back(idx); end
      for (logic [31:0] a = p; a != lim; a++) begin
        exp_b_q.push_back({(a + 1 == lim) && fl[3], byte_at(a)});
        idx++;
      end
      if (fl[4]) exp_irq_at.push_back(idx);
      for (int w = 0; w < 4; w++) begin
        exp_wa_q.push_back(d + 32'(4*w));
        exp_wd_q.push_back(mem[d[9:2]+w]);
      end
      if (fl[0]) begin
        exp_wa_q.push_back(c + 4);
        exp_wd_q.push_back(mem[(c[9:2])+1] | 32'h8000);
        break;
      end
      smd = fl[3];
      d = nx;
    end
  endtask

  // Memory responder, client and per-clock comparison
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
      mem_rvalid = rd_next;
      mem_rdata  = rd_next ? mem[rd_addr[9:2]] : 32'h0;
      rd_next    = 1'b0;
      if (prev_st_wait)
        chk(st_valid && {st_eop, st_data} == prev_st, "R12 beat not held", {st_valid, st_eop, st_data}, {1'b1, prev_st});
      if (prev_md_wait)
        chk(md_valid && md_data == prev_md, "R12 metadata not held", {md_valid, md_data}, {1'b1, prev_md});
      lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      st_ready = lfsr[0] | lfsr[1];
      md_ready = lfsr[2];
      mem_gnt  = lfsr[3] | lfsr[4];
      if (rst_n && st_valid && st_ready) begin
        if (exp_b_q.size() == 0) chk(0, "R3 unexpected byte", {st_eop, st_data}, 0);
        else begin
          chk({st_eop, st_data} == exp_b_q[0], "R2/R3/R4 byte or eop", {st_eop, st_data}, exp_b_q[0]);
          void'(exp_b_q.pop_front());
        end
        bytes_seen++;
      end
      if (rst_n && md_valid && md_ready) begin
        if (exp_md_q.size() == 0) chk(0, "R5 unexpected metadata", md_data, 0);
        else begin
          chk(md_data == exp_md_q[0], "R5 metadata value", md_data, exp_md_q[0]);
          chk(bytes_seen == exp_md_at[0], "R5 metadata position", bytes_seen, exp_md_at[0]);
          void'(exp_md_q.pop_front()); void'(exp_md_at.pop_front());
        end
      end
      if (rst_n && irq_set) begin
        if (exp_irq_at.size() == 0) chk(0, "R6 unexpected interrupt", bytes_seen, 0);
        else begin
          chk(bytes_seen == exp_irq_at[0], "R6/R11 interrupt position", bytes_seen, exp_irq_at[0]);
          void'(exp_irq_at.pop_front());
        end
      end
      if (rst_n && mem_req && mem_gnt) begin
        if (mem_we) begin
          if (exp_wa_q.size() == 0) chk(0, "R7/R8 unexpected write", mem_addr, 0);
          else begin
            chk(mem_addr == exp_wa_q[0], "R7/R8 write address", mem_addr, exp_wa_q[0]);
            chk(mem_wdata == exp_wd_q[0], "R7/R8 write data", mem_wdata, exp_wd_q[0]);
            void'(exp_wa_q.pop_front()); void'(exp_wd_q.pop_front());
          end
          mem[mem_addr[9:2]] = mem_wdata;
        end else begin
          rd_next = 1'b1;
          rd_addr = mem_addr;
        end
      end
      prev_st_wait = st_valid && !st_ready;
      prev_st      = {st_eop, st_data};
      prev_md_wait = md_valid && !md_ready;
      prev_md      = md_data;
    end
  end

  task automatic kick(input logic [31:0] d, input logic [31:0] p, input logic [31:0] c);
    desc_ptr = d; buf_pos = p; ctx_ptr = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run(input string name);
    int n = 0;
    while (running && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R9 run did not stop", n, 20000);
    repeat (3) @(negedge clk);
    chk(exp_b_q.size() == 0, "R9 bytes missing", exp_b_q.size(), 0);
    chk(exp_md_q.size() == 0, "R5 metadata missing", exp_md_q.size(), 0);
    chk(exp_irq_at.size() == 0, "R6 interrupt missing", exp_irq_at.size(), 0);
    chk(exp_wa_q.size() == 0, "R7/R8 writes missing", exp_wa_q.size(), 0);
    chk(eol_flag == 1'b1, "R8 eol flag after stop", eol_flag, 1);
    chk(running == 1'b0, "R8 running after stop", running, 0);
    $display("[TB] %s done", name);
  endtask

  task automatic put_desc(input int a, input logic [31:0] nx, input logic [31:0] s,
                          input logic [31:0] fl, input logic [31:0] lim);
    mem[a/4] = nx; mem[a/4+1] = s; mem[a/4+2] = fl; mem[a/4+3] = lim;
  endtask

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = {8'((4*i+3)*7+1), 8'((4*i+2)*7+1), 8'((4*i+1)*7+1), 8'((4*i)*7+1)};
    // single descriptor, mid-buffer start, eol + eop + intr
    put_desc('h100, 32'h0, 32'h200, 32'hA5A5_0019, 32'h20B);
    mem['h84/4] = 32'h0000_0042;
    // three-descriptor chain; the last is empty
    put_desc('h140, 32'h150, 32'h210, 32'h1111_0000, 32'h225);
    put_desc('h150, 32'h160, 32'h231, 32'h2222_0018, 32'h236);
    put_desc('h160, 32'h0,   32'h240, 32'h3333_0011, 32'h240);
    mem['h94/4] = 32'h0;
    // restart list
    put_desc('h170, 32'h0, 32'h250, 32'h4444_0009, 32'h258);
    mem['hA4/4] = 32'h1234_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!running && !eol_flag && !irq_set, "R1 status after reset", {running, eol_flag, irq_set}, 0);
    chk(!st_valid && !md_valid && !mem_req, "R1 handshakes after reset", {st_valid, md_valid, mem_req}, 0);

    // R2 R3 R4 R6 R7 R8: one descriptor starting at buf_pos
    build(32'h100, 32'h203, 32'h080);
    kick(32'h100, 32'h203, 32'h080);
    chk(running && !eol_flag, "R10 start enters running", {running, eol_flag}, 2'b10);
    finish_run("single");

    // R9 R5 R11 R4 chain, with an ignored start (R10)
    bytes_seen = 0;
    build(32'h140, 32'h210, 32'h090);
    kick(32'h140, 32'h210, 32'h090);
    chk(running && !eol_flag, "R10 start clears eol", {running, eol_flag}, 2'b10);
    repeat (30) @(negedge clk);
    chk(running == 1'b1, "R10 running before second start", running, 1);
    kick(32'h100, 32'h200, 32'h080);
    chk(running == 1'b1, "R10 start while running ignored", running, 1);
    finish_run("chain");

    // restart after end of list
    bytes_seen = 0;
    build(32'h170, 32'h250, 32'h0A0);
    kick(32'h170, 32'h250, 32'h0A0);
    chk(running && !eol_flag, "R10 restart clears eol", {running, eol_flag}, 2'b10);
    finish_run("restart");
    chk(mem['hA4/4] == 32'h1234_8000, "R8 context disable bit", mem['hA4/4], 32'h1234_8000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule